// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block produces the bit clock for one channel of a serial controller. Software writes a 16-bit time constant as two bytes, then sets an enable bit in a control byte. The enable bit's rising edge loads a down-counter. From then on the counter steps once per tick. A tick is either a qualified cycle of the system clock or a rising edge on an external clock pin. Each time the counter has reached zero, the next tick reloads it and flips a square-wave output. The output half-period is therefore the time constant plus one tick.

A separate routing byte sends the square wave to the transmit clock, the receive clock, or both. A direction that is not routed stays low. Clearing the enable bit stops the counter and returns it to zero. Every reload raises a one-cycle zero-count pulse.

Top module: `baud_gen`

## Requirements
- R1: After reset the count is zero and brg_clk, tx_clk, rx_clk and zero_pulse are all low.
- R2: A register write with wr_sel=0 stores wr_data as the low byte of the time constant, and wr_sel=1 stores it as the high byte.
- R3: A write to the control byte (wr_sel=2) that sets bit 0 while the generator is stopped loads the count with the time constant with bit 0 forced to 1. It also drives brg_clk low.
- R4: While running, each tick lowers a non-zero count by one. A tick at count zero instead reloads the stored time constant and inverts brg_clk.
- R5: zero_pulse is high for exactly the one cycle that follows each reload.
- R6: Control bit 1 selects the tick source: 1 selects bus_ce cycles, 0 selects rising edges of ext_clk_pin after a two-flop synchroniser. The source that is not selected has no effect on the count.
- R7: A control write that clears bit 0 while running sets the count to zero and drives brg_clk low. Ticks leave the count at zero while the generator is stopped.
- R8: A time-constant write made while running leaves the count alone and is used at the next reload. A write that lands in the same cycle as a reload does not affect that reload, which uses the value stored before the write.
- R9: The routing byte (wr_sel=3) bit 0 passes brg_clk to tx_clk and bit 1 passes it to rx_clk. An output whose bit is clear is held low.
- R10: A control write that keeps bit 0 set while running does not reload the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 routing |
| wr_data | input | BYTE_W | Write data |
| bus_ce | input | 1 | Bus-clock tick qualifier |
| ext_clk_pin | input | 1 | External clock pin, asynchronous |
| brg_clk | output | 1 | Square-wave generator output |
| tx_clk | output | 1 | Generator clock routed to transmit |
| rx_clk | output | 1 | Generator clock routed to receive |
| zero_pulse | output | 1 | One-cycle pulse on each reload |
| count | output | 2*BYTE_W | Current counter value |

## Verification
A time-constant write can coincide with a reload tick. Both then act on the same clock edge, and the two can disagree about which value is reloaded. The bench first runs the count down to zero. It then asserts bus_ce and a low-byte write in the same cycle. It expects the reload to take the old constant, and expects the new constant to appear only at the following reload, six ticks later.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  typedef enum logic [1:0] {
    SEL_TC_LO = 2'd0,
    SEL_TC_HI = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_ROUTE = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SRC_BIT = 1;
  localparam int ROUTE_TX_BIT = 0;
  localparam int ROUTE_RX_BIT = 1;
  localparam int TC_LANES     = 2;
endpackage

// File: rtl/baud_gen_regs.sv
module baud_gen_regs
  import baud_gen_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  reg_sel_e                     wr_sel,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [TC_LANES*BYTE_W-1:0]   tc,
  output logic                         run,
  output logic                         src_bus,
  output logic                         route_tx,
  output logic                         route_rx,
  output logic                         start,
  output logic                         stop
);
  // one register per time-constant byte lane
  for (genvar g = 0; g < TC_LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q, lane_d;
    always_comb begin
      lane_d = lane_q;
      if (wr_en && wr_sel == reg_sel_e'(g)) lane_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end
    assign tc[g*BYTE_W +: BYTE_W] = lane_q;
  end

  logic run_q, src_q, rtx_q, rrx_q;
  logic run_d, src_d, rtx_d, rrx_d;
  logic ctrl_wr, route_wr;

  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign route_wr = wr_en && (wr_sel == SEL_ROUTE);
  assign start    = ctrl_wr &&  wr_data[CTRL_EN_BIT] && !run_q;
  assign stop     = ctrl_wr && !wr_data[CTRL_EN_BIT] &&  run_q;

  always_comb begin
    run_d = run_q;
    src_d = src_q;
    rtx_d = rtx_q;
    rrx_d = rrx_q;
    if (ctrl_wr) begin
      run_d = wr_data[CTRL_EN_BIT];
      src_d = wr_data[CTRL_SRC_BIT];
    end
    if (route_wr) begin
      rtx_d = wr_data[ROUTE_TX_BIT];
      rrx_d = wr_data[ROUTE_RX_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      src_q <= 1'b0;
      rtx_q <= 1'b0;
      rrx_q <= 1'b0;
    end else begin
      run_q <= run_d;
      src_q <= src_d;
      rtx_q <= rtx_d;
      rrx_q <= rrx_d;
    end
  end

  assign run      = run_q;
  assign src_bus  = src_q;
  assign route_tx = rtx_q;
  assign route_rx = rrx_q;
endmodule

// File: rtl/baud_gen_sync.sv
module baud_gen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] && !prev_q;
endmodule

// File: rtl/baud_gen_cnt.sv
module baud_gen_cnt #(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic            run,
  input  logic            tick,
  input  logic [TC_W-1:0] tc,
  output logic [TC_W-1:0] count,
  output logic            brg,
  output logic            zero_pulse
);
  logic [TC_W-1:0] cnt_q, cnt_d;
  logic            out_q, out_d;
  logic            zp_q, zp_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    zp_d  = 1'b0;
    if (start) begin
      cnt_d = tc | TC_W'(1);
      out_d = 1'b0;
    end else if (stop) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (run && tick) begin
      if (cnt_q == '0) begin
        cnt_d = tc;
        out_d = !out_q;
        zp_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - TC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      zp_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
      zp_q  <= zp_d;
    end
  end

  assign count      = cnt_q;
  assign brg        = out_q;
  assign zero_pulse = zp_q;
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_sel,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic                       bus_ce,
  input  logic                       ext_clk_pin,
  output logic                       brg_clk,
  output logic                       tx_clk,
  output logic                       rx_clk,
  output logic                       zero_pulse,
  output logic [TC_LANES*BYTE_W-1:0] count
);
  localparam int TC_W = TC_LANES * BYTE_W;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [TC_W-1:0] tc;
  logic run, src_bus, route_tx, route_rx, start, stop;
  logic pin_rise, tick;

  baud_gen_regs #(.BYTE_W(BYTE_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_sel   (reg_sel_e'(wr_sel)),
    .wr_data  (wr_data),
    .tc       (tc),
    .run      (run),
    .src_bus  (src_bus),
    .route_tx (route_tx),
    .route_rx (route_rx),
    .start    (start),
    .stop     (stop)
  );

  baud_gen_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pin   (ext_clk_pin),
    .rise  (pin_rise)
  );

  assign tick = src_bus ? bus_ce : pin_rise;

  baud_gen_cnt #(.TC_W(TC_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .stop       (stop),
    .run        (run),
    .tick       (tick),
    .tc         (tc),
    .count      (count),
    .brg        (brg_clk),
    .zero_pulse (zero_pulse)
  );

  assign tx_clk = brg_clk && route_tx;
  assign rx_clk = brg_clk && route_rx;
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int TC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            brg_clk,
  input logic            zero_pulse,
  input logic [TC_W-1:0] count
);
  // R7: a stopped generator holds a zero count and a low output
  a_r7_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (count == '0) && !brg_clk);

  // R3: the start edge loads an odd count and a low output
  a_r3_start_odd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> count[0] && !brg_clk);

  // R5: every zero pulse accompanies an output flip
  a_r5_pulse_flips: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |-> brg_clk != $past(brg_clk));

  // R4: while running, the output changes only at a reload
  a_r4_flip_needs_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && brg_clk != $past(brg_clk)) |-> zero_pulse);

  // R4: outside a reload, a running count moves only downward by one
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !zero_pulse && count != $past(count))
      |-> count == $past(count) - TC_W'(1));
endmodule

bind baud_gen baud_gen_chk #(.TC_W(2*BYTE_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .run        (run),
  .brg_clk    (brg_clk),
  .zero_pulse (zero_pulse),
  .count      (count)
);

// File: tb/test_baud_gen.sv
module test_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        bus_ce = 1'b0;
  logic        ext_clk_pin = 1'b0;
  logic        brg_clk, tx_clk, rx_clk, zero_pulse;
  logic [15:0] count;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = !clk;

  baud_gen i_baud_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bus_ce(bus_ce), .ext_clk_pin(ext_clk_pin), .brg_clk(brg_clk), .tx_clk(tx_clk),
    .rx_clk(rx_clk), .zero_pulse(zero_pulse), .count(count)
  );

  typedef struct packed {
    logic [15:0] tc;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic        exp_out;
  } vec_t;

  // start value is tc|1; half period is tc+1 ticks
  localparam vec_t VEC [6] = '{
    '{16'h0004, 8'd3,  16'h0002, 1'b0},
    '{16'h0004, 8'd6,  16'h0004, 1'b1},
    '{16'h0004, 8'd11, 16'h0004, 1'b0},
    '{16'h0000, 8'd2,  16'h0000, 1'b1},
    '{16'h0102, 8'd3,  16'h0100, 1'b0},
    '{16'h0003, 8'd4,  16'h0003, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bus_ce = 1'b1;
      @(negedge clk); bus_ce = 1'b0;
    end
  endtask

  task automatic pin_pulse();
    @(negedge clk); ext_clk_pin = 1'b1;
    repeat (3) @(negedge clk);
    ext_clk_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 count", count, 16'h0);
    check("R1 brg_clk", {15'd0, brg_clk}, 16'h0);
    check("R1 tx/rx", {14'd0, tx_clk, rx_clk}, 16'h0);
    check("R1 zero_pulse", {15'd0, zero_pulse}, 16'h0);

    // R2 R3 R4 table of time constants and tick counts
    foreach (VEC[i]) begin
      wr(2'd2, 8'h00);
      wr(2'd0, VEC[i].tc[7:0]);
      wr(2'd1, VEC[i].tc[15:8]);
      wr(2'd2, 8'h03);
      ticks(int'(VEC[i].ticks));
      check("R4 count", count, VEC[i].exp_cnt);
      check("R4 brg_clk", {15'd0, brg_clk}, {15'd0, VEC[i].exp_out});
    end

    // R9 routing (brg_clk is high here)
    wr(2'd3, 8'h01);
    check("R9 tx only", {14'd0, tx_clk, rx_clk}, 16'h2);
    wr(2'd3, 8'h02);
    check("R9 rx only", {14'd0, tx_clk, rx_clk}, 16'h1);
    wr(2'd3, 8'h00);
    check("R9 none", {14'd0, tx_clk, rx_clk}, 16'h0);

    // R10 re-enable without edge keeps count
    wr(2'd2, 8'h03);
    check("R10 count kept", count, 16'h0003);

    // R7 stop clears and ignores ticks
    wr(2'd2, 8'h00);
    check("R7 count cleared", count, 16'h0);
    check("R7 brg low", {15'd0, brg_clk}, 16'h0);
    ticks(3);
    check("R7 ticks ignored", count, 16'h0);

    // R3 forced odd start; R8 write while running; R5 pulse width
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h03);
    check("R3 start load", count, 16'h0003);
    wr(2'd0, 8'h05);
    check("R8 count untouched", count, 16'h0003);
    ticks(3);
    check("R4 at zero", count, 16'h0);
    check("R5 no pulse yet", {15'd0, zero_pulse}, 16'h0);
    @(negedge clk); bus_ce = 1'b1;
    @(negedge clk); bus_ce = 1'b0;
    check("R8 new value at reload", count, 16'h0005);
    check("R5 pulse high", {15'd0, zero_pulse}, 16'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {15'd0, zero_pulse}, 16'h0);

    // R8 write coincident with reload uses old constant
    ticks(5);
    check("R8 at zero", count, 16'h0);
    @(negedge clk);
    bus_ce = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h07;
    @(negedge clk);
    bus_ce = 1'b0; wr_en = 1'b0;
    check("R8 same-cycle old value", count, 16'h0005);
    ticks(6);
    check("R8 next reload new value", count, 16'h0007);

    // R6 external source
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h01);
    check("R6 ext start", count, 16'h0003);
    ticks(3);
    check("R6 bus ignored", count, 16'h0003);
    pin_pulse();
    pin_pulse();
    repeat (4) @(negedge clk);
    check("R6 pin ticks", count, 16'h0001);
    wr(2'd2, 8'h03);
    check("R10 source switch no reload", count, 16'h0001);
    ticks(1);
    check("R6 bus ticks", count, 16'h0000);
    pin_pulse();
    repeat (4) @(negedge clk);
    check("R6 pin ignored", count, 16'h0000);

    report();
  end
endmodule